// File: doc/BRIEF.md
# Four-Way Minimum Position Finder

This block looks at four unsigned operands of equal width and reports which of them holds the smallest value. It reports a 2-bit position, not the value itself. A consumer uses that position to steer a selection, for example to pick the least-loaded queue or the earliest deadline out of four candidates. When operands are equal, the lowest position wins, so the answer is deterministic.

Two internal structures can produce the position, and a parameter picks one:

- **Pairwise tournament.** Two first-round comparisons each keep the smaller member of a pair. A final comparison decides between the two pair winners. The final decision forms the upper position bit and also chooses which first-round decision becomes the lower bit.
- **MSB-first elimination.** All four operands are scanned from the top bit down. At every bit, candidates holding a 1 are dropped whenever some remaining candidate holds a 0. The lowest-numbered survivor is reported.

An optional output register captures the position on a clock edge when the input qualifier is high. It raises a valid flag in the following cycle.

Top module: `minsel4`

## Requirements
- R1: The reported position names an operand whose value is less than or equal to each of the four operands.
- R2: When several operands share the minimum value, the reported position is the lowest among them; every operand at a smaller position is strictly greater.
- R3: The position is coded in binary: 0 means `cand0`, 1 means `cand1`, 2 means `cand2` and 3 means `cand3`. Bit 1 is 0 exactly when the winner is in the pair `cand0`/`cand1`.
- R4: The elimination structure (`IMPL`=1) reports the same position as the tournament structure (`IMPL`=0) for every input combination.
- R5: With the output register enabled, the position for inputs presented while `in_vld` is high appears on `min_idx` one rising edge later, and `min_vld` is high in that same cycle.
- R6: With the output register enabled, an edge where `in_vld` is low leaves `min_idx` unchanged and drives `min_vld` low, whatever the operands are.
- R7: A rising edge with `rst` high (synchronous, active high) sets `min_idx` to 0 and `min_vld` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_vld | input | 1 | Qualifies the operands for capture |
| cand0 | input | W | Operand at position 0 |
| cand1 | input | W | Operand at position 1 |
| cand2 | input | W | Operand at position 2 |
| cand3 | input | W | Operand at position 3 |
| min_idx | output | 2 | Position of the smallest operand |
| min_vld | output | 1 | Marks `min_idx` as fresh |

## Verification
A wrong first-round decision in the tournament does not always show. It reaches the ports only when its pair also wins the final comparison. A flipped final decision points at the wrong pair at once. Either fault appears on `min_idx` one edge after the offending operands are captured, so the bench walks every operand combination for the default width. Tie-breaking faults show up only on equal operands, which the exhaustive sweep covers. A mismatch between the two structures shows up as a difference between two instances that are driven identically.

// File: rtl/minsel_pkg.sv
package minsel_pkg;
  localparam int NCAND = 4;
  localparam int IDXW  = $clog2(NCAND);
  typedef logic [IDXW-1:0] pos_t;
endpackage

// File: rtl/minsel_tourney.sv
module minsel_tourney
  import minsel_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [NCAND-1:0][W-1:0] cands,
  output pos_t                    pos
);
  // 1 when rhs is strictly smaller, so equal values favour lhs (lower position)
  function automatic logic rhs_wins(input logic [W-1:0] lhs, input logic [W-1:0] rhs);
    return (rhs < lhs);
  endfunction

  function automatic logic [W-1:0] pick_val(input logic sel, input logic [W-1:0] lhs,
                                            input logic [W-1:0] rhs);
    return sel ? rhs : lhs;
  endfunction

  logic [1:0]        pair_sel;   // first-round decisions
  logic [1:0][W-1:0] pair_win;   // first-round winning values
  logic              final_sel;  // final-round decision

  for (genvar p = 0; p < 2; p++) begin : g_pair
    assign pair_sel[p] = rhs_wins(cands[2*p], cands[2*p+1]);
    assign pair_win[p] = pick_val(pair_sel[p], cands[2*p], cands[2*p+1]);

    always_comb begin
      // R1
      pair_min_chk: assert (pair_win[p] <= cands[2*p] && pair_win[p] <= cands[2*p+1]);
    end
  end

  assign final_sel = rhs_wins(pair_win[0], pair_win[1]);
  assign pos       = {final_sel, (final_sel ? pair_sel[1] : pair_sel[0])};

  always_comb begin
    // R2
    pair_tie_chk: assert (cands[0] != cands[1] || pair_sel[0] == 1'b0);
  end
endmodule

// File: rtl/minsel_elim.sv
module minsel_elim
  import minsel_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [NCAND-1:0][W-1:0] cands,
  output pos_t                    pos
);
  function automatic logic [NCAND-1:0] survivors(input logic [NCAND-1:0][W-1:0] v);
    logic [NCAND-1:0] alive;
    logic [NCAND-1:0] zeros;
    alive = '1;
    for (int b = W - 1; b >= 0; b--) begin
      for (int k = 0; k < NCAND; k++) zeros[k] = alive[k] & ~v[k][b];
      if (|zeros) alive = zeros;
    end
    return alive;
  endfunction

  function automatic pos_t lowest_set(input logic [NCAND-1:0] m);
    pos_t r;
    r = '0;
    for (int k = NCAND - 1; k >= 0; k--) if (m[k]) r = pos_t'(k);
    return r;
  endfunction

  logic [NCAND-1:0] alive_mask;

  assign alive_mask = survivors(cands);
  assign pos        = lowest_set(alive_mask);

  always_comb begin
    // R2
    survivor_equal_chk: assert (alive_mask[pos] == 1'b1);
  end
endmodule

// File: rtl/minsel4.sv
module minsel4
  import minsel_pkg::*;
#(
  parameter int W       = 4,
  parameter int IMPL    = 0,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] cand0,
  input  logic [W-1:0] cand1,
  input  logic [W-1:0] cand2,
  input  logic [W-1:0] cand3,
  output logic [1:0]   min_idx,
  output logic         min_vld
);
  logic [NCAND-1:0][W-1:0] cands;
  pos_t                    core_pos;
  logic [W-1:0]            core_val;

  assign cands    = {cand3, cand2, cand1, cand0};
  assign core_val = cands[core_pos];

  if (IMPL == 0) begin : g_tourney
    minsel_tourney #(.W(W)) u_core (.cands(cands), .pos(core_pos));
  end else begin : g_elim
    minsel_elim #(.W(W)) u_core (.cands(cands), .pos(core_pos));
  end

  if (REG_OUT) begin : g_reg
    pos_t idx_q;
    logic vld_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        idx_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= in_vld;
        if (in_vld) idx_q <= core_pos;
      end
    end
    assign min_idx = idx_q;
    assign min_vld = vld_q;

    // R5
    capture_chk: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> (min_vld && min_idx == $past(core_pos)));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> (!min_vld && $stable(min_idx)));
    // R7
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (min_idx == 2'd0 && !min_vld));
  end else begin : g_comb
    assign min_idx = core_pos;
    assign min_vld = in_vld;
  end

  // R1
  is_minimum_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> (core_val <= cand0 && core_val <= cand1 &&
                core_val <= cand2 && core_val <= cand3));
  // R2
  lowest_tie_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> ((core_pos == 2'd0 || cand0 > core_val) &&
                (core_pos <  2'd2 || cand1 > core_val) &&
                (core_pos != 2'd3 || cand2 > core_val)));
endmodule

// File: tb/minsel4_bench.sv
module minsel4_bench;
  localparam int W      = 4;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [W-1:0] c0 = '0, c1 = '0, c2 = '0, c3 = '0;
  logic [1:0]   idx_t, idx_e;
  logic         vld_t, vld_e;
  int           checks = 0;
  int           fails = 0;
  bit           done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  minsel4 #(.W(W), .IMPL(0), .REG_OUT(1'b1)) u_minsel4 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .cand0(c0), .cand1(c1), .cand2(c2), .cand3(c3),
    .min_idx(idx_t), .min_vld(vld_t));

  minsel4 #(.W(W), .IMPL(1), .REG_OUT(1'b1)) u_minsel4_elim (
    .clk(clk), .rst(rst), .in_vld(in_vld), .cand0(c0), .cand1(c1), .cand2(c2), .cand3(c3),
    .min_idx(idx_e), .min_vld(vld_e));

  // Reference: scan positions upward, replace only on strictly smaller value
  function automatic logic [1:0] ref_pos(input logic [W-1:0] a, b, c, d);
    logic [W-1:0] v [4];
    int best;
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    best = 0;
    for (int k = 1; k < 4; k++) if (v[k] < v[best]) best = k;
    return 2'(best);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, b, c, d, input string req);
    logic [1:0] e;
    @(negedge clk);
    c0 = a; c1 = b; c2 = c; c3 = d; in_vld = 1'b1;
    e = ref_pos(a, b, c, d);
    @(posedge clk); #1;
    check(req, int'(idx_t), int'(e));
    check("R4", int'(idx_e), int'(e));
    check("R5", int'(vld_t), 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] held;
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state
    check("R7", int'(idx_t), 0);
    check("R7", int'(vld_t), 0);
    @(negedge clk); rst = 1'b0;

    // R3: each position reachable, encoding 0..3
    apply(4'd1, 4'd5, 4'd6, 4'd7, "R3");
    apply(4'd9, 4'd2, 4'd6, 4'd7, "R3");
    apply(4'd9, 4'd8, 4'd0, 4'd7, "R3");
    apply(4'd9, 4'd8, 4'd6, 4'd3, "R3");
    // R2: ties resolve to lowest position
    apply(4'd5, 4'd5, 4'd5, 4'd5, "R2");
    apply(4'd9, 4'd4, 4'd7, 4'd4, "R2");
    apply(4'd8, 4'd9, 4'd3, 4'd3, "R2");
    apply(4'd15, 4'd15, 4'd15, 4'd14, "R2");

    // R6: hold with in_vld low while operands change
    @(negedge clk);
    held = idx_t;
    in_vld = 1'b0; c0 = 4'd0; c1 = 4'd15; c2 = 4'd15; c3 = 4'd15;
    @(posedge clk); #1;
    check("R6", int'(idx_t), int'(held));
    check("R6", int'(vld_t), 0);

    // R1 / R4: every combination of the four operands
    for (int n = 0; n < 65536; n++)
      apply(4'(n), 4'(n >> 4), 4'(n >> 8), 4'(n >> 12), "R1");

    // R1: random mix with fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 500; n++)
      apply(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), "R1");

    // R7: reset in mid-stream
    @(negedge clk); rst = 1'b1; in_vld = 1'b1;
    @(posedge clk); #1;
    check("R7", int'(idx_t), 0);
    check("R7", int'(vld_t), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule